// File: doc/BRIEF.md
# Audio Stream Format Monitor

This block watches two status words that describe an incoming audio stream and turns them into decoded stream parameters: channel count, sample width, sample rate, the IEC 60958 channel status byte and the category code. Each accepted sample of the two words is decoded. The sample rate is worked out by a small sequential multiply and divide. The result is then compared with the last recorded format. When any field differs, the recorded copy is replaced and a one-cycle update request tells downstream logic to rebuild whatever it derives from the audio format.

The recorded format starts out invalid after reset: channel count, width and rate are zero, which no legal sample can produce. The first accepted sample therefore always raises an update. Separately, the block follows a "buffer filled" flag taken from a status byte. While the interface is enabled, it emits a one-cycle strobe each time that flag changes.

Top module: `aud_fmt_monitor`

## Requirements
- R1: `channels` equals rate_word[2:0] plus one, so the range is 1 to 8.
- R2: rate_word[7:4] selects the sample width: code 0 gives 8, 1 gives 16, 2 gives 20, 3 gives 24 and 4 gives 32. Any other code yields 16 and drives `width_err` high. `width_err` is updated at each comparison and is low for a legal code.
- R3: `rate_hz` equals base * (rate_word[13:11] + 1) / (rate_word[10:8] + 1), with the quotient truncated. The base is 44100 when rate_word[14] is 1 and 48000 when it is 0.
- R4: `iec_status` is stat_word[7:0] and `category` is stat_word[15:8].
- R5: `update_req` is high for exactly one cycle when any of the five decoded fields differs from the recorded value. The outputs take the new values in that same cycle. If nothing differs, `update_req` stays low and every field output holds.
- R6: After reset, all field outputs, `width_err`, `update_req`, `busy`, `buf_filled` and `buf_change` are zero. The first accepted sample therefore always raises `update_req`.
- R7: A sample is accepted on a clock edge where `sample_valid` is high and `busy` is low. `busy` then stays high, and the result with its `update_req` appears 25 edges after the accepting edge (1 + 4 multiply steps + 20 divide steps). Any `sample_valid` seen while `busy` is high is ignored.
- R8: The buffer flag is bit 4 of `buf_word`. While `enable` is high, the flag is sampled every edge. `buf_filled` shows the last sample, and `buf_change` is high for one cycle after any edge where the new sample differs from the previous one. While `enable` is low, `buf_change` stays low and `buf_filled` holds.
- R9: The buffer strobe and the update request are independent. Both may be high in the same cycle, and neither suppresses the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Offers the two format words for sampling |
| rate_word | input | 16 | Channels, width code, divisor, multiplier, base select |
| stat_word | input | 16 | Channel status byte and category code |
| enable | input | 1 | Interface enable for buffer-flag tracking |
| buf_word | input | 8 | Status byte carrying the buffer-filled flag in bit 4 |
| channels | output | 4 | Recorded channel count |
| sample_bits | output | 6 | Recorded sample width in bits |
| rate_hz | output | 20 | Recorded sample rate in Hz |
| iec_status | output | 8 | Recorded IEC 60958 status byte |
| category | output | 8 | Recorded category code |
| width_err | output | 1 | Last compared sample had an unknown width code |
| update_req | output | 1 | One-cycle format change request |
| busy | output | 1 | Rate computation in progress |
| buf_filled | output | 1 | Last sampled buffer-filled flag |
| buf_change | output | 1 | One-cycle buffer flag change strobe |

## Verification
The update request and the buffer-change strobe can land in the same cycle. The bench provokes this by toggling the buffer flag on the edge just before the comparison edge of a sample that changes the format. It then checks that both strobes are high together in the cycle after that edge, and that both drop one cycle later. A second same-cycle overlap is a new `sample_valid` arriving while a computation is still running. The bench judges it by the final outputs: they must match the first sample and finish on the original schedule.

// File: rtl/afm_pkg.sv
package afm_pkg;
  localparam int CH_W  = 4;
  localparam int SB_W  = 6;
  localparam int IEC_W = 8;
  localparam int CAT_W = 8;

  typedef struct packed {
    logic [CH_W-1:0]  chans;
    logic [SB_W-1:0]  sbits;
    logic [IEC_W-1:0] iec;
    logic [CAT_W-1:0] cat;
  } fmt_t;

  // Returns {error, width}; unknown codes fall back to 16 bits.
  function automatic logic [SB_W:0] width_lookup(input logic [3:0] code);
    case (code)
      4'd0:    width_lookup = {1'b0, SB_W'(8)};
      4'd1:    width_lookup = {1'b0, SB_W'(16)};
      4'd2:    width_lookup = {1'b0, SB_W'(20)};
      4'd3:    width_lookup = {1'b0, SB_W'(24)};
      4'd4:    width_lookup = {1'b0, SB_W'(32)};
      default: width_lookup = {1'b1, SB_W'(16)};
    endcase
  endfunction
endpackage

// File: rtl/afm_field_decode.sv
module afm_field_decode
  import afm_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int RATE_W  = 20,
  parameter int OP_W    = 4,
  parameter int BASE_LO = 44100,
  parameter int BASE_HI = 48000
) (
  input  logic [WORD_W-1:0] rate_word,
  input  logic [WORD_W-1:0] stat_word,
  output fmt_t              fmt,
  output logic              width_err,
  output logic [RATE_W-1:0] base_rate,
  output logic [OP_W-1:0]   mul_op,
  output logic [OP_W-1:0]   div_op
);
  logic [SB_W:0] wl;
  logic          unused_bits;

  assign wl          = width_lookup(rate_word[7:4]);
  assign unused_bits = ^{rate_word[WORD_W-1:15], rate_word[3]};

  always_comb begin
    fmt.chans = CH_W'(rate_word[2:0]) + CH_W'(1);
    fmt.sbits = wl[SB_W-1:0];
    fmt.iec   = stat_word[IEC_W-1:0];
    fmt.cat   = stat_word[IEC_W +: CAT_W];
    width_err = wl[SB_W];
    base_rate = rate_word[14] ? RATE_W'(BASE_LO) : RATE_W'(BASE_HI);
    mul_op    = OP_W'(rate_word[13:11]) + OP_W'(1);
    div_op    = OP_W'(rate_word[10:8]) + OP_W'(1);
  end
endmodule

// File: rtl/afm_rate_calc.sv
module afm_rate_calc #(
  parameter int RATE_W = 20,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RATE_W-1:0] base,
  input  logic [OP_W-1:0]   mul_op,
  input  logic [OP_W-1:0]   div_op,
  output logic              done,
  output logic [RATE_W-1:0] result
);
  localparam int CNT_W = $clog2(RATE_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_DIV} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [RATE_W-1:0] acc, mcand, quo;
  logic [OP_W-1:0]   mplier, divisor, rem;
  logic [RATE_W-1:0] acc_nx, quo_nx;
  logic [OP_W:0]     rem_sh, rem_sub;
  logic              ge;

  always_comb begin
    acc_nx  = mplier[0] ? acc + mcand : acc;
    rem_sh  = {rem, quo[RATE_W-1]};
    ge      = rem_sh >= {1'b0, divisor};
    rem_sub = ge ? rem_sh - {1'b0, divisor} : rem_sh;
    quo_nx  = {quo[RATE_W-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      acc     <= '0;
      mcand   <= '0;
      quo     <= '0;
      mplier  <= '0;
      divisor <= '0;
      rem     <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          acc     <= '0;
          mcand   <= base;
          mplier  <= mul_op;
          divisor <= div_op;
          cnt     <= '0;
          st      <= S_MUL;
        end
        S_MUL: begin
          acc    <= acc_nx;
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
          cnt    <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(OP_W - 1)) begin
            quo <= acc_nx;
            rem <= '0;
            cnt <= '0;
            st  <= S_DIV;
          end
        end
        S_DIV: begin
          quo <= quo_nx;
          rem <= rem_sub[OP_W-1:0];
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(RATE_W - 1)) begin
            done   <= 1'b1;
            result <= quo_nx;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: a divide never runs with a zero divisor
  a_r3_div_nonzero: assert property (@(posedge clk) disable iff (rst)
    (st == S_DIV) |-> (divisor != '0));
  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/afm_buf_watch.sv
module afm_buf_watch #(
  parameter int SW_W    = 8,
  parameter int FLAG_IX = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic [SW_W-1:0] buf_word,
  output logic            filled,
  output logic            change
);
  logic flag_now;
  logic unused_word;

  assign flag_now    = buf_word[FLAG_IX];
  assign unused_word = ^(buf_word & ~(SW_W'(1) << FLAG_IX));

  always_ff @(posedge clk) begin
    if (rst) begin
      filled <= 1'b0;
      change <= 1'b0;
    end else if (enable) begin
      filled <= flag_now;
      change <= flag_now != filled;
    end else begin
      change <= 1'b0;
    end
  end

  // R8: no strobe follows a disabled cycle
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !change);
  // R8: the recorded flag does not move while disabled
  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(filled));
endmodule

// File: rtl/aud_fmt_monitor.sv
module aud_fmt_monitor
  import afm_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int RATE_W  = 20,
  parameter int OP_W    = 4,
  parameter int SW_W    = 8,
  parameter int FLAG_IX = 4,
  parameter int BASE_LO = 44100,
  parameter int BASE_HI = 48000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  input  logic [WORD_W-1:0] rate_word,
  input  logic [WORD_W-1:0] stat_word,
  input  logic              enable,
  input  logic [SW_W-1:0]   buf_word,
  output logic [CH_W-1:0]   channels,
  output logic [SB_W-1:0]   sample_bits,
  output logic [RATE_W-1:0] rate_hz,
  output logic [IEC_W-1:0]  iec_status,
  output logic [CAT_W-1:0]  category,
  output logic              width_err,
  output logic              update_req,
  output logic              busy,
  output logic              buf_filled,
  output logic              buf_change
);
  fmt_t              dec_fmt, pend_fmt, rec_fmt;
  logic              dec_err, pend_err, accept, calc_done, differs;
  logic [RATE_W-1:0] dec_base, calc_rate, rec_rate;
  logic [OP_W-1:0]   dec_mul, dec_div;

  afm_field_decode #(
    .WORD_W(WORD_W), .RATE_W(RATE_W), .OP_W(OP_W),
    .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
  ) u_dec (
    .rate_word(rate_word), .stat_word(stat_word),
    .fmt(dec_fmt), .width_err(dec_err),
    .base_rate(dec_base), .mul_op(dec_mul), .div_op(dec_div)
  );

  assign accept = sample_valid && !busy;

  afm_rate_calc #(.RATE_W(RATE_W), .OP_W(OP_W)) u_rate (
    .clk(clk), .rst(rst), .start(accept),
    .base(dec_base), .mul_op(dec_mul), .div_op(dec_div),
    .done(calc_done), .result(calc_rate)
  );

  afm_buf_watch #(.SW_W(SW_W), .FLAG_IX(FLAG_IX)) u_buf (
    .clk(clk), .rst(rst), .enable(enable), .buf_word(buf_word),
    .filled(buf_filled), .change(buf_change)
  );

  assign differs = (pend_fmt != rec_fmt) || (calc_rate != rec_rate);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_fmt   <= '0;
      pend_err   <= 1'b0;
      rec_fmt    <= '0;
      rec_rate   <= '0;
      width_err  <= 1'b0;
      update_req <= 1'b0;
      busy       <= 1'b0;
    end else begin
      update_req <= 1'b0;
      if (accept) begin
        pend_fmt <= dec_fmt;
        pend_err <= dec_err;
        busy     <= 1'b1;
      end
      if (calc_done) begin
        busy       <= 1'b0;
        width_err  <= pend_err;
        update_req <= differs;
        if (differs) begin
          rec_fmt  <= pend_fmt;
          rec_rate <= calc_rate;
        end
      end
    end
  end

  assign channels    = rec_fmt.chans;
  assign sample_bits = rec_fmt.sbits;
  assign iec_status  = rec_fmt.iec;
  assign category    = rec_fmt.cat;
  assign rate_hz     = rec_rate;

  // R5: the request is one cycle wide
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
    update_req |=> !update_req);
  // R5: recorded fields move only together with a request
  a_r5_fields_hold: assert property (@(posedge clk) disable iff (rst)
    !update_req |-> $stable({channels, sample_bits, rate_hz, iec_status, category}));
  // R7: a request only appears once the computation has finished
  a_r7_req_idle: assert property (@(posedge clk) disable iff (rst)
    update_req |-> !busy);
  // R7: an offer during a computation does not end it early
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !calc_done) |=> busy);
endmodule

// File: tb/aud_fmt_monitor_tb.sv
module aud_fmt_monitor_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_valid = 1'b0;
  logic [15:0] rate_word = '0;
  logic [15:0] stat_word = '0;
  logic        enable = 1'b0;
  logic [7:0]  buf_word = '0;
  logic [3:0]  channels;
  logic [5:0]  sample_bits;
  logic [19:0] rate_hz;
  logic [7:0]  iec_status, category;
  logic        width_err, update_req, busy, buf_filled, buf_change;

  int checks = 0;
  int fails  = 0;
  localparam int LAT = 25;

  always #10 clk = ~clk;

  aud_fmt_monitor u_dut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid),
    .rate_word(rate_word), .stat_word(stat_word), .enable(enable),
    .buf_word(buf_word), .channels(channels), .sample_bits(sample_bits),
    .rate_hz(rate_hz), .iec_status(iec_status), .category(category),
    .width_err(width_err), .update_req(update_req), .busy(busy),
    .buf_filled(buf_filled), .buf_change(buf_change)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit b44, input int mul, input int dv,
                                     input int wc, input int ch);
    return {1'b0, b44, 3'(mul), 3'(dv), 4'(wc), 1'b0, 3'(ch)};
  endfunction

  function automatic int exp_rate(input bit b44, input int mul, input int dv);
    return ((b44 ? 44100 : 48000) * (mul + 1)) / (dv + 1);
  endfunction

  // Offers one sample; returns edges counted until busy drops.
  // tog_at >= 0 toggles the buffer flag at that count.
  task automatic send(input logic [15:0] rw, input logic [15:0] sw,
                      input int tog_at, output int n);
    @(negedge clk);
    sample_valid = 1'b1; rate_word = rw; stat_word = sw;
    @(negedge clk);
    sample_valid = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      if (n == tog_at) buf_word[4] = ~buf_word[4];
      @(negedge clk);
      n++;
    end
  endtask

  task automatic expect_fmt(input string req, input int ch, input int sb,
                            input int rt, input int iec, input int cat);
    chk({req, " channels"}, channels, ch);
    chk({req, " sample_bits"}, sample_bits, sb);
    chk({req, " rate_hz"}, rate_hz, rt);
    chk({req, " iec_status"}, iec_status, iec);
    chk({req, " category"}, category, cat);
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect_fmt("R6 reset", 0, 0, 0, 0, 0);
    chk("R6 reset update_req", update_req, 0);
    chk("R6 reset busy", busy, 0);
    chk("R6 reset width_err", width_err, 0);
    chk("R6 reset buf_change", buf_change, 0);
  endtask

  task automatic t_first;
    int n;
    send(mk(0, 0, 0, 1, 1), 16'h0000, -1, n);
    chk("R7 latency", n, LAT);
    chk("R6 first sample update_req", update_req, 1);
    expect_fmt("R1 first", 2, 16, 48000, 0, 0);
    @(negedge clk);
    chk("R5 pulse width", update_req, 0);
  endtask

  task automatic t_repeat;
    int n;
    send(mk(0, 0, 0, 1, 1), 16'h0000, -1, n);
    chk("R5 unchanged no update", update_req, 0);
    expect_fmt("R5 unchanged hold", 2, 16, 48000, 0, 0);
  endtask

  task automatic t_status;
    int n;
    send(mk(0, 0, 0, 1, 1), 16'h5AC3, -1, n);
    chk("R4 status change update", update_req, 1);
    expect_fmt("R4 fields", 2, 16, 48000, 8'hC3, 8'h5A);
  endtask

  task automatic t_rates;
    int n;
    send(mk(1, 3, 2, 1, 1), 16'h5AC3, -1, n);
    chk("R3 rate-only change update", update_req, 1);
    chk("R3 44.1k x4 /3", rate_hz, exp_rate(1, 3, 2));
    send(mk(0, 7, 6, 4, 7), 16'h5AC3, -1, n);
    chk("R3 48k x8 /7 truncated", rate_hz, exp_rate(0, 7, 6));
    chk("R1 eight channels", channels, 8);
    chk("R2 code 4", sample_bits, 32);
    send(mk(1, 7, 0, 4, 7), 16'h5AC3, -1, n);
    chk("R3 max rate", rate_hz, exp_rate(1, 7, 0));
  endtask

  task automatic t_widths;
    int n;
    send(mk(0, 0, 0, 2, 0), 16'h0001, -1, n);
    chk("R2 code 2", sample_bits, 20);
    chk("R1 one channel", channels, 1);
    send(mk(0, 0, 0, 3, 0), 16'h0001, -1, n);
    chk("R2 code 3", sample_bits, 24);
    send(mk(0, 0, 0, 0, 0), 16'h0001, -1, n);
    chk("R2 code 0", sample_bits, 8);
    send(mk(0, 0, 0, 9, 0), 16'h0001, -1, n);
    chk("R2 bad code fallback", sample_bits, 16);
    chk("R2 bad code flag", width_err, 1);
    chk("R2 bad code update", update_req, 1);
    send(mk(0, 0, 0, 1, 0), 16'h0001, -1, n);
    chk("R2 legal code clears flag", width_err, 0);
    chk("R2 same width no update", update_req, 0);
  endtask

  task automatic t_busy_ignore;
    int n;
    @(negedge clk);
    sample_valid = 1'b1; rate_word = mk(1, 1, 0, 3, 5); stat_word = 16'h1111;
    @(negedge clk);
    sample_valid = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      if (n == 5) begin
        sample_valid = 1'b1; rate_word = mk(0, 2, 3, 0, 2); stat_word = 16'h2222;
      end else begin
        sample_valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    sample_valid = 1'b0;
    chk("R7 latency with ignored offer", n, LAT);
    expect_fmt("R7 ignored offer", 6, 24, exp_rate(1, 1, 0), 8'h11, 8'h11);
    repeat (3) @(negedge clk);
    chk("R7 no late start", busy, 0);
  endtask

  task automatic t_buffer;
    enable = 1'b1;
    buf_word = 8'hEF;
    @(negedge clk);
    chk("R8 other bits ignored", buf_change, 0);
    buf_word = 8'h10;
    @(negedge clk);
    chk("R8 rise strobe", buf_change, 1);
    chk("R8 filled", buf_filled, 1);
    @(negedge clk);
    chk("R8 strobe one cycle", buf_change, 0);
    enable = 1'b0;
    buf_word = 8'h00;
    repeat (2) @(negedge clk);
    chk("R8 disabled no strobe", buf_change, 0);
    chk("R8 disabled holds", buf_filled, 1);
    enable = 1'b1;
    @(negedge clk);
    chk("R8 re-enable strobe", buf_change, 1);
    chk("R8 re-enable value", buf_filled, 0);
  endtask

  task automatic t_overlap;
    int n;
    enable = 1'b1;
    send(mk(0, 1, 1, 1, 3), 16'h3344, LAT - 1, n);
    chk("R9 overlap update_req", update_req, 1);
    chk("R9 overlap buf_change", buf_change, 1);
    @(negedge clk);
    chk("R9 both drop update_req", update_req, 0);
    chk("R9 both drop buf_change", buf_change, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_first();
    t_repeat();
    t_status();
    t_rates();
    t_widths();
    t_busy_ignore();
    t_buffer();
    t_overlap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule